// File: doc/BRIEF.md
# Sixteen-Function ALU with Condition Flags

This block is the arithmetic and logic unit of a small microprogrammed processor datapath. It is purely combinational from its two operand buses and its 4-bit function select to its result bus. It also produces four condition flags: negative, zero, overflow and carry. A strobe marks the functions whose flags the status register should capture. Every select value is a valid function, so the unit is never idle. Microcode that does not want the flags disturbed picks a function from the non-flag-setting half.

The function set is built to interpret instructions. It has flag-setting and silent versions of AND, OR, NOR and add, and a variable logical right shift. It has two fixed left shifts for scaling displacement fields, 13-bit immediate extraction with zero fill or sign fill, and increment by one and by four for stepping the program counter. It also has a fixed 5-place arithmetic right shift used when picking apart branch fields. A small flag store, loaded on a rising clock edge while the strobe is high, sits beside the ALU so that the strobe's effect can be seen at the ports.

Top module: `cc_alu_core`

## Requirements
- R1: The select codes are 0 ANDCC, 1 ORCC, 2 NORCC, 3 ADDCC, 4 SRL, 5 AND, 6 OR, 7 NOR, 8 ADD, 9 LSHIFT2, 10 LSHIFT10, 11 SIMM13, 12 SEXT13, 13 INC, 14 INCPC, 15 RSHIFT5. The AND, OR and NOR functions give the bitwise AND, OR and NOR of `opa` and `opb`, both with and without flag setting.
- R2: ADD and ADDCC give the two's complement sum `opa + opb`, modulo 2^32.
- R3: `set_cc` is 1 exactly when `fsel[3:2]` is 00, which covers codes 0 to 3.
- R4: SRL shifts `opa` right by `opb[4:0]` places with zero fill. Bits `opb[31:5]` have no effect on the result.
- R5: LSHIFT2 and LSHIFT10 shift `opa` left by 2 and by 10 places with zero fill.
- R6: SIMM13 gives `opa[12:0]` with bits 31..13 cleared. SEXT13 gives `opa[12:0]` with bits 31..13 all equal to `opa[12]`.
- R7: INC gives `opa + 1` and INCPC gives `opa + 4`, both modulo 2^32.
- R8: RSHIFT5 shifts `opa` right by 5 places and fills bits 31..27 with `opa[31]`.
- R9: Flag bit 3 (n) equals result bit 31. Flag bit 2 (z) is 1 only when all 32 result bits are 0.
- R10: For ADD, ADDCC, INC and INCPC, flag bit 0 (c) is the carry out of bit 31. For the same four functions, flag bit 1 (v) is the carry into bit 31 XOR the carry out of bit 31. For every other function, both bits are 0.
- R11: `flags_q` resets to 0. On a rising edge with `set_cc` high it loads `flags`. On a rising edge with `set_cc` low it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag store |
| rst_n | input | 1 | Active-low asynchronous reset of the flag store |
| opa | input | 32 | First operand bus |
| opb | input | 32 | Second operand bus; also carries the shift amount for SRL |
| fsel | input | 4 | Function select |
| result | output | 32 | Function result |
| flags | output | 4 | Combinational flags {n, z, v, c} |
| set_cc | output | 1 | High when the selected function updates the flags |
| flags_q | output | 4 | Registered flags {n, z, v, c} |

## Verification
The bench runs all sixteen functions against the operands 0, all ones, 0x7FFFFFFF and 0x80000000, then against random operands. Positive overflow out of 0x7FFFFFFF and negative overflow out of 0x80000000 catch a v built from the sign bits alone, or from the wrong carry. All ones plus one and plus four catch a lost carry out and a z that misses a wrapped result. SRL with large `opb` values catches a shifter that reads more than five amount bits, and negative operands under RSHIFT5 and SEXT13 catch zero fill where sign fill belongs. Each function is followed by a clock edge, which shows a flag store that loads on a silent function or misses a flag-setting one.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
   typedef enum logic [3:0] {
      OP_ANDCC  = 4'd0,
      OP_ORCC   = 4'd1,
      OP_NORCC  = 4'd2,
      OP_ADDCC  = 4'd3,
      OP_SRL    = 4'd4,
      OP_AND    = 4'd5,
      OP_OR     = 4'd6,
      OP_NOR    = 4'd7,
      OP_ADD    = 4'd8,
      OP_SHL_S  = 4'd9,
      OP_SHL_L  = 4'd10,
      OP_ZIMM   = 4'd11,
      OP_SIMM   = 4'd12,
      OP_INC1   = 4'd13,
      OP_INCW   = 4'd14,
      OP_ASR_F  = 4'd15
   } alu_op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_V = 1;
   localparam int FLAG_C = 0;
endpackage

// File: rtl/cc_alu_adder.sv
module cc_alu_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             carry_msb
);
   localparam int LOW_W = WIDTH - 1;

   logic [WIDTH-1:0] low_sum;
   logic [1:0]       top_sum;

   // Split the add so the carry into the top bit is visible for overflow.
   assign low_sum   = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]};
   assign carry_msb = low_sum[LOW_W];
   assign top_sum   = {1'b0, a[WIDTH-1]} + {1'b0, b[WIDTH-1]} + {1'b0, carry_msb};
   assign sum       = {top_sum[0], low_sum[LOW_W-1:0]};
   assign carry_out = top_sum[1];
endmodule

// File: rtl/cc_alu_shift.sv
module cc_alu_shift #(
   parameter int WIDTH = 32,
   localparam int SH_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SH_W-1:0]  amt,
   input  logic             left,
   input  logic             arith,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage [SH_W+1];

   assign stage[0] = din;

   // One level per amount bit; level k moves by 2**k places.
   for (genvar k = 0; k < SH_W; k++) begin : g_level
      localparam int DIST = 1 << k;
      logic [WIDTH-1:0] moved;
      always_comb begin
         if (left)
            moved = stage[k] << DIST;
         else if (arith)
            moved = $unsigned($signed(stage[k]) >>> DIST);
         else
            moved = stage[k] >> DIST;
      end
      assign stage[k+1] = amt[k] ? moved : stage[k];
   end

   assign dout = stage[SH_W];
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res,
   input  logic             arith_en,
   input  logic             carry_out,
   input  logic             carry_msb,
   output logic [3:0]       flg
);
   import cc_alu_pkg::*;

   always_comb begin
      flg         = '0;
      flg[FLAG_N] = res[WIDTH-1];
      flg[FLAG_Z] = ~|res;
      flg[FLAG_C] = arith_en & carry_out;
      flg[FLAG_V] = arith_en & (carry_out ^ carry_msb);
   end
endmodule

// File: rtl/cc_alu_flagreg.sv
module cc_alu_flagreg #(
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [FW-1:0] d,
   output logic [FW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/cc_alu_core.sv
module cc_alu_core #(
   parameter int WIDTH     = 32,
   parameter int IMM_W     = 13,
   parameter int SHL_SHORT = 2,
   parameter int SHL_LONG  = 10,
   parameter int ASR_FIXED = 5,
   parameter int PC_STEP   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [3:0]       fsel,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags,
   output logic             set_cc,
   output logic [3:0]       flags_q
);
   import cc_alu_pkg::*;

   localparam int SH_W  = $clog2(WIDTH);
   localparam int EXT_W = WIDTH - IMM_W;

   if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("cc_alu_core: WIDTH must be a power of two of at least 8");
   end
   if (IMM_W < 2 || IMM_W >= WIDTH) begin : g_bad_imm
      $error("cc_alu_core: IMM_W must lie between 2 and WIDTH-1");
   end
   if (SHL_SHORT >= WIDTH || SHL_LONG >= WIDTH || ASR_FIXED >= WIDTH) begin : g_bad_shift
      $error("cc_alu_core: fixed shift distances must be below WIDTH");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] add_b;
   logic [WIDTH-1:0] sum;
   logic             carry_out;
   logic             carry_msb;
   logic             arith_en;
   logic [SH_W-1:0]  sh_amt;
   logic             sh_left;
   logic             sh_arith;
   logic [WIDTH-1:0] sh_out;

   assign op = alu_op_e'(fsel);

   // Second adder input: operand bus, or a constant step for the increments.
   always_comb begin
      unique case (op)
         OP_INC1: add_b = WIDTH'(1);
         OP_INCW: add_b = WIDTH'(PC_STEP);
         default: add_b = opb;
      endcase
   end

   assign arith_en = (op == OP_ADD) || (op == OP_ADDCC) ||
                     (op == OP_INC1) || (op == OP_INCW);

   cc_alu_adder #(.WIDTH(WIDTH)) u_adder (
      .a         (opa),
      .b         (add_b),
      .sum       (sum),
      .carry_out (carry_out),
      .carry_msb (carry_msb)
   );

   // Shift control: variable amount only for SRL, fixed distances otherwise.
   always_comb begin
      sh_amt   = '0;
      sh_left  = 1'b0;
      sh_arith = 1'b0;
      unique case (op)
         OP_SRL:   sh_amt = opb[SH_W-1:0];
         OP_SHL_S: begin sh_amt = SH_W'(SHL_SHORT); sh_left = 1'b1; end
         OP_SHL_L: begin sh_amt = SH_W'(SHL_LONG);  sh_left = 1'b1; end
         OP_ASR_F: begin sh_amt = SH_W'(ASR_FIXED); sh_arith = 1'b1; end
         default:  ;
      endcase
   end

   cc_alu_shift #(.WIDTH(WIDTH)) u_shift (
      .din   (opa),
      .amt   (sh_amt),
      .left  (sh_left),
      .arith (sh_arith),
      .dout  (sh_out)
   );

   always_comb begin
      unique case (op)
         OP_ANDCC, OP_AND: result = opa & opb;
         OP_ORCC,  OP_OR:  result = opa | opb;
         OP_NORCC, OP_NOR: result = ~(opa | opb);
         OP_ADDCC, OP_ADD, OP_INC1, OP_INCW: result = sum;
         OP_ZIMM:  result = {{EXT_W{1'b0}}, opa[IMM_W-1:0]};
         OP_SIMM:  result = {{EXT_W{opa[IMM_W-1]}}, opa[IMM_W-1:0]};
         default:  result = sh_out;
      endcase
   end

   cc_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res       (result),
      .arith_en  (arith_en),
      .carry_out (carry_out),
      .carry_msb (carry_msb),
      .flg       (flags)
   );

   assign set_cc = ~fsel[3] & ~fsel[2];

   cc_alu_flagreg #(.FW(4)) u_flagreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (set_cc),
      .d     (flags),
      .q     (flags_q)
   );
endmodule

// File: rtl/cc_alu_core_chk.sv
module cc_alu_core_chk #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] opa,
   input logic [3:0]       fsel,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       flags,
   input logic             set_cc,
   input logic [3:0]       flags_q
);
   localparam int TOP_W = WIDTH - IMM_W + 1;

   assert_cc_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_cc |=> (flags_q == $past(flags)));

   assert_cc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !set_cc |=> $stable(flags_q));

   assert_neg_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags[3] == result[WIDTH-1]);

   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags[2] == (result == '0));

   assert_logic_cv_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel <= 4'd2) |-> (flags[1:0] == 2'b00));

   assert_zimm_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel == 4'd11) |-> (result[WIDTH-1:IMM_W] == '0));

   assert_simm_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel == 4'd12) |-> ($countones(result[WIDTH-1:IMM_W-1]) == 0 ||
                           $countones(result[WIDTH-1:IMM_W-1]) == TOP_W));

   assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel >= 4'd4) |-> !set_cc);

   assert_asr_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel == 4'd15) |-> (result[WIDTH-1] == opa[WIDTH-1]));
endmodule

bind cc_alu_core cc_alu_core_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .opa     (opa),
   .fsel    (fsel),
   .result  (result),
   .flags   (flags),
   .set_cc  (set_cc),
   .flags_q (flags_q)
);

// File: tb/cc_alu_core_tb.sv
module cc_alu_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [3:0]  fsel = '0;
   logic [31:0] result;
   logic [3:0]  flags;
   logic        set_cc;
   logic [3:0]  flags_q;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_q = '0;

   always #5 clk = ~clk;

   cc_alu_core u_dut (
      .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .fsel(fsel),
      .result(result), .flags(flags), .set_cc(set_cc), .flags_q(flags_q)
   );

   function automatic string req_of(input logic [3:0] f);
      case (f)
         4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7: return "R1";
         4'd3, 4'd8:   return "R2";
         4'd4:         return "R4";
         4'd9, 4'd10:  return "R5";
         4'd11, 4'd12: return "R6";
         4'd13, 4'd14: return "R7";
         default:      return "R8";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s fsel=%0d a=%h b=%h actual=%h expected=%h", req, fsel, opa, opb, act, exp);
      end
   endtask

   task automatic run_vec(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
      logic [32:0] s;
      logic [31:0] r;
      logic [31:0] badd;
      logic        ar;
      logic        c;
      logic        v;
      logic        scc;
      logic [3:0]  fl;
      @(negedge clk);
      fsel = f; opa = a; opb = b;
      ar = (f == 4'd3) || (f == 4'd8) || (f == 4'd13) || (f == 4'd14);
      badd = (f == 4'd13) ? 32'd1 : (f == 4'd14) ? 32'd4 : b;
      s = {1'b0, a} + {1'b0, badd};
      case (f)
         4'd0, 4'd5: r = a & b;
         4'd1, 4'd6: r = a | b;
         4'd2, 4'd7: r = ~(a | b);
         4'd4:       r = a >> b[4:0];
         4'd9:       r = a << 2;
         4'd10:      r = a << 10;
         4'd11:      r = {19'd0, a[12:0]};
         4'd12:      r = {{19{a[12]}}, a[12:0]};
         4'd15:      r = $unsigned($signed(a) >>> 5);
         default:    r = s[31:0];
      endcase
      c = ar & s[32];
      v = ar & (a[31] == badd[31]) & (s[31] != a[31]);
      fl = {r[31], (r == 32'd0), v, c};
      scc = (f[3:2] == 2'b00);
      #1;
      check(req_of(f), result, r);
      check("R9", {30'd0, flags[3:2]}, {30'd0, fl[3:2]});
      check("R10", {30'd0, flags[1:0]}, {30'd0, fl[1:0]});
      check("R3", {31'd0, set_cc}, {31'd0, scc});
      if (scc) exp_q = fl;
      @(posedge clk);
      #1;
      check("R11", {28'd0, flags_q}, {28'd0, exp_q});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [31:0] corners [8];
      corners[0] = 32'h0000_0000;
      corners[1] = 32'hFFFF_FFFF;
      corners[2] = 32'h7FFF_FFFF;
      corners[3] = 32'h8000_0000;
      corners[4] = 32'h0000_1000;
      corners[5] = 32'hFFFF_FFE3;
      corners[6] = 32'h0000_0FFF;
      corners[7] = 32'hA5A5_5A5A;
      repeat (3) @(posedge clk);
      #1;
      check("R11", {28'd0, flags_q}, 32'd0);
      rst_n = 1'b1;
      for (int f = 0; f < 16; f++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               run_vec(4'(f), corners[i], corners[j]);
      for (int k = 0; k < 3000; k++)
         run_vec(4'($urandom_range(0, 15)), $urandom, $urandom);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule